// File: doc/BRIEF.md
# Port Link Width Controller

This block manages the lane width of a four-lane serial link port. It keeps a maximum-width setting that can be changed only while a separate unlock bit is set. The setting is copied into the active limit at the moment a full link training (one that passes through the Detect state) begins. When the training-complete strobe arrives, the block works out the negotiated width from that limit and from a per-lane "usable" vector supplied by the training logic. It then publishes the width as a read-only status value and drives one power-down output per physical lane.

Logical lanes can sit on the physical lanes in normal order or in reversed order. Reversed order is used only when the normal placement fails. After a full training, a dynamic request can lower the width, or raise it again, without passing through Detect. A request never raises the width above what the last full training reached. The configuration bus, the training state machine and the electrical lanes lie outside the block. They connect through simple strobes and level signals.

Top module: `link_width_ctrl`

## Requirements
- R1: After reset the maximum-width readback is x4 (code 4), the unlock readback is 0, the negotiated width is 0 (link down) and all four lane power-down outputs are 1.
- R2: Width codes are 1 = x1, 2 = x2, 4 = x4 and 0 = link down. A write to the maximum width is accepted only when the unlock bit was already set before the write cycle and the value is 1, 2 or 4. Any other write leaves the readback unchanged.
- R3: A new maximum width has no effect on the active link. It is copied into the active limit on the cycle `train_start` is seen. From the cycle after `train_start` until the training-complete result, the negotiated width reads 0.
- R4: A full training resolves to the largest of 4, 2 or 1 that does not exceed the limit copied at `train_start` and whose lanes are all usable. `lane_ok[i]` refers to physical lane i. Normal order uses physical lanes 0..w-1; reversed order uses physical lanes 3 down to 4-w. If no width fits in either order, the result is 0.
- R5: `lane_rev` is 1 only when the resolved width is non-zero and fits only in reversed order. Normal order is preferred whenever it fits.
- R6: While the port is enabled, each `lane_pd[i]` is 0 exactly for the physical lanes carrying a logical lane and 1 for the others. When the width is 0, all four are 1.
- R7: While `port_en` is 0, all `lane_pd` bits are 1 and the negotiated width reads 0. Re-enabling the port restores the previous width and lane mapping without a new training.
- R8: A dynamic request is captured from `dyn_req` with `dyn_width`. It is applied at the next `train_done` and is resolved like R4, with the limit set to the smaller of the requested width and the width of the last full training. A dynamic request never changes that ceiling.
- R9: A training result appears on the outputs in the cycle after the `train_done` strobe. A `train_done` with no pending training or request leaves every output unchanged.
- R10: `dyn_req` is ignored in three cases: the link is down, `dyn_width` is not 1, 2 or 4, or a full training is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unlock_we | input | 1 | Write strobe for the unlock bit |
| unlock_wdata | input | 1 | New unlock bit value |
| maxw_we | input | 1 | Write strobe for the maximum width |
| maxw_wdata | input | 3 | New maximum width code |
| unlock_q | output | 1 | Unlock bit readback |
| max_width | output | 3 | Maximum width readback |
| port_en | input | 1 | Port enable; 0 powers down every lane |
| train_start | input | 1 | Pulse: a full training entered Detect |
| train_done | input | 1 | Pulse: training complete, resolve the width |
| lane_ok | input | 4 | Per physical lane: usable |
| dyn_req | input | 1 | Pulse: dynamic width change request |
| dyn_width | input | 3 | Requested width code |
| neg_width | output | 3 | Negotiated width status |
| lane_rev | output | 1 | Reversed lane order in effect |
| lane_pd | output | 4 | Per physical lane power-down |

## Verification
The bench sweeps every legal maximum width against all sixteen lane-usable patterns. It also sweeps every requested dynamic code against all sixteen patterns, computing the expected width, orientation and power-down mask arithmetically. This catches a resolver that prefers reversed order, accepts a partial lane set, or ignores the limit. The bench targets four more corner cases:
- A width raised above the ceiling of the last full training, which would show up as an x4 result after an x2 training.
- A maximum-width write taking effect on a live link, or being taken while locked.
- An idle `train_done` or a request made while the link is down, which a careless sequencer would turn into a fresh width.
- A disabled port that still leaves lanes powered, or loses its width when it is re-enabled.

// File: rtl/lwc_pkg.sv
// Shared types and helpers for the link width controller.
// Assumes the lane count is a power of two; width codes are plain lane counts.
package lwc_pkg;
    parameter int unsigned LWC_LANES = 4;
    parameter int unsigned LWC_WB    = $clog2(LWC_LANES) + 1;

    typedef logic [LWC_WB-1:0]    width_t;
    typedef logic [LWC_LANES-1:0] lanes_t;

    // True when the code names a single supported width (a power of two up to the lane count).
    function automatic logic is_legal(width_t w);
        return ($countones(w) == 1) && (int'(w) <= int'(LWC_LANES));
    endfunction

    // Physical lanes used by width w in normal (low lanes) or reversed (high lanes) order.
    function automatic lanes_t lane_mask(width_t w, logic rev);
        lanes_t m;
        for (int i = 0; i < int'(LWC_LANES); i++) begin
            m[i] = rev ? ((int'(LWC_LANES) - 1 - i) < int'(w)) : (i < int'(w));
        end
        return m;
    endfunction
endpackage

// File: rtl/lwc_cfg_regs.sv
// Lockable maximum-width setting and its unlock bit.
// Assumes writes are single-cycle strobes. A width write is judged against the
// unlock value held before the write cycle; illegal width codes are dropped.
module lwc_cfg_regs
    import lwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   unlock_we,
    input  logic   unlock_wdata,
    input  logic   maxw_we,
    input  width_t maxw_wdata,
    output logic   unlock_q,
    output width_t max_q
);
    localparam width_t RESET_MAX = width_t'(LWC_LANES);

    // Holds the unlock bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         unlock_q <= 1'b0;
        else if (unlock_we) unlock_q <= unlock_wdata;
    end

    // Holds the maximum width; it changes only on an unlocked, legal write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       max_q <= RESET_MAX;
        else if (maxw_we && unlock_q && is_legal(maxw_wdata)) max_q <= maxw_wdata;
    end

    assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_q |=> $stable(max_q));
    assert_max_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_legal(max_q));
endmodule

// File: rtl/lwc_resolver.sv
// Combinational width resolver.
// For each candidate width (powers of two up to the lane count), it checks the
// limit and lane usability in both orders, then picks the largest fit.
// Normal order wins over reversed order at the same width.
module lwc_resolver
    import lwc_pkg::*;
(
    input  width_t limit,
    input  lanes_t lane_ok,
    output width_t res_width,
    output logic   res_rev
);
    localparam int NCAND = $clog2(LWC_LANES) + 1;

    logic [NCAND-1:0] fit_n;
    logic [NCAND-1:0] fit_r;

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam width_t CW = width_t'(1 << k);
        localparam lanes_t MN = lane_mask(CW, 1'b0);
        localparam lanes_t MR = lane_mask(CW, 1'b1);
        assign fit_n[k] = (limit >= CW) && ((lane_ok & MN) == MN);
        assign fit_r[k] = (limit >= CW) && ((lane_ok & MR) == MR);
    end

    // Scan candidates upward so the widest fitting one is kept.
    always_comb begin
        res_width = '0;
        res_rev   = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            if (fit_n[k]) begin
                res_width = width_t'(1 << k);
                res_rev   = 1'b0;
            end else if (fit_r[k]) begin
                res_width = width_t'(1 << k);
                res_rev   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lwc_lane_power.sv
// Lane power-down and status gating.
// Powers down every physical lane outside the active mapping, or all of them
// while the port is disabled. The status width reads 0 while disabled.
module lwc_lane_power
    import lwc_pkg::*;
(
    input  logic   port_en,
    input  width_t width_q,
    input  logic   rev_q,
    output lanes_t lane_pd,
    output width_t neg_width,
    output logic   lane_rev
);
    // Derives the per-lane power-down mask and the gated status values.
    always_comb begin
        lane_pd   = port_en ? ~lane_mask(width_q, rev_q) : '1;
        neg_width = port_en ? width_q : '0;
        lane_rev  = port_en && rev_q && (width_q != '0);
    end
endmodule

// File: rtl/link_width_ctrl.sv
// Port link width controller top.
// Sequences full trainings and dynamic requests: it copies the limit at
// train_start, applies the resolver result one cycle after train_done, and
// keeps the ceiling set by the last full training.
// Assumes train_start, train_done and dyn_req are single-cycle pulses.
module link_width_ctrl
    import lwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 unlock_we,
    input  logic                 unlock_wdata,
    input  logic                 maxw_we,
    input  logic [LWC_WB-1:0]    maxw_wdata,
    output logic                 unlock_q,
    output logic [LWC_WB-1:0]    max_width,
    input  logic                 port_en,
    input  logic                 train_start,
    input  logic                 train_done,
    input  logic [LWC_LANES-1:0] lane_ok,
    input  logic                 dyn_req,
    input  logic [LWC_WB-1:0]    dyn_width,
    output logic [LWC_WB-1:0]    neg_width,
    output logic                 lane_rev,
    output logic [LWC_LANES-1:0] lane_pd
);
    width_t max_q, lat_max_q, cap_q, width_q, dyn_tgt_q;
    logic   rev_q, pend_full_q, pend_dyn_q;
    width_t res_width, limit;
    logic   res_rev;

    lwc_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .unlock_we    (unlock_we),
        .unlock_wdata (unlock_wdata),
        .maxw_we      (maxw_we),
        .maxw_wdata   (maxw_wdata),
        .unlock_q     (unlock_q),
        .max_q        (max_q)
    );
    assign max_width = max_q;

    // Selects the resolver limit: the copied maximum for a full training, else the dynamic target.
    assign limit = pend_full_q ? lat_max_q : dyn_tgt_q;

    lwc_resolver u_res (
        .limit     (limit),
        .lane_ok   (lane_ok),
        .res_width (res_width),
        .res_rev   (res_rev)
    );

    // Sequences trainings and requests; train_start has priority over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_max_q   <= width_t'(LWC_LANES);
            cap_q       <= '0;
            width_q     <= '0;
            rev_q       <= 1'b0;
            pend_full_q <= 1'b0;
            pend_dyn_q  <= 1'b0;
            dyn_tgt_q   <= '0;
        end else if (train_start) begin
            lat_max_q   <= max_q;
            pend_full_q <= 1'b1;
            pend_dyn_q  <= 1'b0;
            width_q     <= '0;
            rev_q       <= 1'b0;
        end else if (train_done && pend_full_q) begin
            width_q     <= res_width;
            rev_q       <= res_rev;
            cap_q       <= res_width;
            pend_full_q <= 1'b0;
        end else if (train_done && pend_dyn_q) begin
            width_q     <= res_width;
            rev_q       <= res_rev;
            pend_dyn_q  <= 1'b0;
        end else if (dyn_req && !pend_full_q && (width_q != '0) && is_legal(dyn_width)) begin
            pend_dyn_q  <= 1'b1;
            dyn_tgt_q   <= (dyn_width < cap_q) ? dyn_width : cap_q;
        end
    end

    lwc_lane_power u_pwr (
        .port_en   (port_en),
        .width_q   (width_q),
        .rev_q     (rev_q),
        .lane_pd   (lane_pd),
        .neg_width (neg_width),
        .lane_rev  (lane_rev)
    );

    assert_down_in_train_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> (neg_width == '0));
    assert_within_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= lat_max_q);
    assert_under_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= cap_q);
    assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (train_done && !train_start && !pend_full_q && !pend_dyn_q) |=> $stable(width_q));
    assert_off_all_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> ($countones(lane_pd) == LWC_LANES));
    assert_powered_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> ($countones(~lane_pd) == int'(neg_width)));
endmodule

// File: tb/link_width_ctrl_bench.sv
`timescale 1ns/1ps
module link_width_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unlock_we = 0, unlock_wdata = 0, maxw_we = 0;
    logic [2:0] maxw_wdata = 0;
    logic       unlock_q;
    logic [2:0] max_width;
    logic       port_en = 1, train_start = 0, train_done = 0, dyn_req = 0;
    logic [3:0] lane_ok = 0;
    logic [2:0] dyn_width = 0;
    logic [2:0] neg_width;
    logic       lane_rev;
    logic [3:0] lane_pd;

    int n_tests = 0, n_fail = 0;
    int m_cap = 0, m_w = 0;
    bit m_rev = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    link_width_ctrl u_link_width_ctrl (
        .clk(clk), .rst_n(rst_n),
        .unlock_we(unlock_we), .unlock_wdata(unlock_wdata),
        .maxw_we(maxw_we), .maxw_wdata(maxw_wdata),
        .unlock_q(unlock_q), .max_width(max_width),
        .port_en(port_en), .train_start(train_start), .train_done(train_done),
        .lane_ok(lane_ok), .dyn_req(dyn_req), .dyn_width(dyn_width),
        .neg_width(neg_width), .lane_rev(lane_rev), .lane_pd(lane_pd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected resolution: widest of 4,2,1 within lim, normal order first.
    function automatic void exp_res(input int lim, input logic [3:0] ok,
                                    output int w, output bit rv);
        w = 0; rv = 0;
        for (int c = 4; c >= 1; c = c / 2) begin
            logic [3:0] nm, rm;
            nm = 4'((1 << c) - 1);
            rm = 4'(nm << (4 - c));
            if (w == 0 && c <= lim) begin
                if ((ok & nm) == nm)      begin w = c; rv = 0; end
                else if ((ok & rm) == rm) begin w = c; rv = 1; end
            end
        end
    endfunction

    function automatic logic [3:0] exp_pd(input int w, input bit rv);
        logic [3:0] nm;
        nm = 4'((1 << w) - 1);
        if (w == 0) return 4'hF;
        return rv ? ~4'(nm << (4 - w)) : ~nm;
    endfunction

    task automatic check_link(input string tag);
        chk(neg_width == 3'(m_w), {tag, " width"}, neg_width, m_w);
        chk(lane_rev == (m_rev && m_w != 0), {tag, " rev"}, lane_rev, m_rev);
        chk(lane_pd == exp_pd(m_w, m_rev), {tag, " pd"}, lane_pd, exp_pd(m_w, m_rev));
    endtask

    task automatic write_cfg(input bit ul, input bit do_w, input logic [2:0] v);
        @(negedge clk);
        unlock_we = 1; unlock_wdata = ul;
        @(negedge clk);
        unlock_we = 0;
        if (do_w) begin maxw_we = 1; maxw_wdata = v; end
        @(negedge clk);
        maxw_we = 0;
    endtask

    task automatic full_train(input logic [3:0] ok);
        int lim;
        @(negedge clk);
        train_start = 1;
        lim = int'(max_width);
        @(negedge clk);
        train_start = 0;
        chk(neg_width == 0, "R3 down during training", neg_width, 0);
        lane_ok = ok; train_done = 1;
        @(negedge clk);
        train_done = 0;
        exp_res(lim, ok, m_w, m_rev);
        m_cap = m_w;
    endtask

    task automatic dyn_change(input logic [2:0] dw, input logic [3:0] ok);
        int lim, w; bit rv;
        bit acc;
        acc = (m_w != 0) && (dw == 1 || dw == 2 || dw == 4);
        @(negedge clk);
        dyn_req = 1; dyn_width = dw;
        @(negedge clk);
        dyn_req = 0; lane_ok = ok; train_done = 1;
        check_link("R9 unchanged before done");
        @(negedge clk);
        train_done = 0;
        if (acc) begin
            lim = (int'(dw) < m_cap) ? int'(dw) : m_cap;
            exp_res(lim, ok, w, rv);
            m_w = w; m_rev = rv;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(max_width == 4, "R1 max reset", max_width, 4);
        chk(unlock_q == 0, "R1 unlock reset", unlock_q, 0);
        chk(neg_width == 0, "R1 width reset", neg_width, 0);
        chk(lane_pd == 4'hF, "R1 pd reset", lane_pd, 15);

        // R2 locked write ignored, illegal code ignored
        write_cfg(0, 1, 3'd2);
        chk(max_width == 4, "R2 locked write", max_width, 4);
        write_cfg(1, 1, 3'd3);
        chk(max_width == 4, "R2 illegal code", max_width, 4);
        write_cfg(1, 1, 3'd0);
        chk(max_width == 4, "R2 zero code", max_width, 4);
        write_cfg(1, 1, 3'd2);
        chk(max_width == 2, "R2 unlocked write", max_width, 2);

        // R4 R5 R6 sweep: every legal maximum with every lane pattern
        for (int mi = 0; mi < 3; mi++) begin
            write_cfg(1, 1, 3'(1 << mi));
            for (int ok = 0; ok < 16; ok++) begin
                full_train(4'(ok));
                check_link("R4 R5 R6 full sweep");
            end
        end

        // R3 maximum change does not touch a live link
        write_cfg(1, 1, 3'd4);
        full_train(4'hF);
        write_cfg(1, 1, 3'd1);
        check_link("R3 live link kept");
        full_train(4'hF);
        check_link("R3 applied at next training");
        chk(neg_width == 1, "R3 x1 after retrain", neg_width, 1);
        write_cfg(1, 1, 3'd4);

        // R8 R10 dynamic sweep from a full x4 link
        for (int dw = 0; dw < 8; dw++) begin
            for (int ok = 0; ok < 16; ok++) begin
                full_train(4'hF);
                dyn_change(3'(dw), 4'(ok));
                check_link("R8 R10 dynamic sweep");
            end
        end

        // R8 down then up restores x4
        full_train(4'hF);
        dyn_change(3'd1, 4'hF);
        chk(neg_width == 1, "R8 down to x1", neg_width, 1);
        dyn_change(3'd4, 4'hF);
        chk(neg_width == 4, "R8 back to x4", neg_width, 4);

        // R8 ceiling from an x2 training
        full_train(4'b0011);
        dyn_change(3'd4, 4'hF);
        chk(neg_width == 2, "R8 ceiling x2", neg_width, 2);
        check_link("R8 ceiling map");

        // R10 request while link down
        full_train(4'b0000);
        dyn_change(3'd1, 4'hF);
        chk(neg_width == 0, "R10 down link request", neg_width, 0);

        // R10 request while full training pending is dropped
        @(negedge clk); train_start = 1;
        @(negedge clk); train_start = 0; dyn_req = 1; dyn_width = 3'd1;
        @(negedge clk); dyn_req = 0; lane_ok = 4'hF; train_done = 1;
        @(negedge clk); train_done = 0;
        m_w = 4; m_rev = 0; m_cap = 4;
        check_link("R10 request during training");
        lane_ok = 4'h1; train_done = 1;
        @(negedge clk); train_done = 0;
        check_link("R10 no stale request");

        // R9 idle done ignored
        @(negedge clk);
        check_link("R9 idle done");

        // R7 disable and re-enable
        full_train(4'b1100);
        check_link("R7 pre-disable");
        port_en = 0;
        @(negedge clk);
        chk(lane_pd == 4'hF, "R7 disabled pd", lane_pd, 15);
        chk(neg_width == 0, "R7 disabled width", neg_width, 0);
        port_en = 1;
        @(negedge clk);
        check_link("R7 re-enabled");

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule